// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for one SDRAM read or write burst. A mode word is latched into an internal register when the load strobe is pulsed. The block decodes three settings from that word: the burst length, the ordering (sequential or interleaved) and a write-single flag. When a start pulse arrives with a start column and a read/write flag, the block emits one column address per clock. Each address comes with a valid flag, and the final beat also carries a last flag.

A memory controller places this block next to its command sequencer. It decides how many beats a burst has and in what order the columns are visited, including 256-column full-page bursts. A stop input ends a running burst at once, whatever its length. A reserved length setting raises an error flag, and bursts then fall back to a single beat.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_vld, col_last and mode_err are 0. The mode register clears to zero, which selects one beat and sequential order.
- R2: A cycle with mode_ld high latches mode_din. The new settings apply to the next accepted start, and mode_err reflects them in the cycle after the loading edge.
- R3: A start sampled while no burst is running gives a first beat with col_addr equal to start_col in the next cycle. A start sampled during a burst is ignored.
- R4: Length field mode_din[2:0] selects the beat count: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. Beats follow one per clock with no gaps.
- R5: With mode_din[3]=0 (sequential), beat k adds k to the low log2(N) bits of the start column and wraps within the N-aligned block. The upper bits stay unchanged.
- R6: With mode_din[3]=1 (interleaved), beat k is the start column with its low log2(N) bits XORed with k.
- R7: Length code 111 with sequential order gives a 256-beat burst. It counts up from the start column and wraps from 255 to 0.
- R8: Length codes 100, 101 and 110 are reserved, and so is code 111 with interleaved order. For any of these, mode_err is 1 and every burst is a single beat.
- R9: With mode_din[9]=1, a write start (start_wr=1) gives a single beat. A read still uses the programmed length.
- R10: A stop sampled at an edge during a burst ends the burst, so col_vld is 0 in the next cycle. This holds at every length, including full page. A stop while idle has no effect.
- R11: col_last is high only together with col_vld, and only on beat N-1. col_vld is 0 in the cycle after a last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ld | input | 1 | Latch mode_din into the mode register |
| mode_din | input | 10 | Mode word: [2:0] length, [3] order, [9] write-single |
| start | input | 1 | Begin a burst |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| start_col | input | 8 | First column of the burst |
| stop | input | 1 | End the running burst |
| col_addr | output | 8 | Column address of the current beat |
| col_vld | output | 1 | col_addr carries a beat |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Latched mode word holds a reserved length setting |

## Verification
The first beat of a burst is due in the cycle after the edge that samples start. Beat k then follows k cycles later. The end of a burst shows up one cycle after the edge that samples stop or that ends the last beat, and mode_err follows one cycle after a mode load. The driver pushes each expected beat into a queue before it raises start. The monitor pops and compares on every falling edge where col_vld is high, so each result is taken half a cycle after the edge that produced it. Once a burst is over, the bench checks that the queue is empty and that col_vld is low. This catches both missing beats and extra beats.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int COL_W  = 8;
  localparam int MODE_W = 10;
  localparam int LG_W   = $clog2(COL_W + 1);

  localparam int LEN_LSB  = 0;
  localparam int ORDER_B  = 3;
  localparam int WSNGL_B  = 9;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int LW = LG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ld,
  input  logic [MW-1:0] mode_din,
  output logic [LW-1:0] lg_mode,
  output logic          il_mode,
  output logic          wr_single,
  output logic          err
);
  localparam logic [LW-1:0] LG_PAGE = LW'(COL_W);

  logic [MW-1:0] mode_q, mode_d;
  logic [2:0]    code;

  always_comb begin
    mode_d = mode_q;
    if (mode_ld) mode_d = mode_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_ld) mode_q <= mode_d;
  end

  assign code      = mode_q[LEN_LSB +: 3];
  assign il_mode   = mode_q[ORDER_B];
  assign wr_single = mode_q[WSNGL_B];

  always_comb begin
    lg_mode = '0;
    err     = 1'b0;
    unique case (code)
      LEN_1:    lg_mode = LW'(0);
      LEN_2:    lg_mode = LW'(1);
      LEN_4:    lg_mode = LW'(2);
      LEN_8:    lg_mode = LW'(3);
      LEN_PAGE: begin
        if (il_mode) err = 1'b1;
        else         lg_mode = LG_PAGE;
      end
      default:  err = 1'b1;
    endcase
  end
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int LW = LG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic [CW-1:0] start_col,
  input  logic          stop,
  input  logic [LW-1:0] lg_mode,
  input  logic          il_mode,
  input  logic          wr_single,
  input  logic          err,
  output logic          busy,
  output logic          last,
  output logic [CW-1:0] base,
  output logic [CW-1:0] beat,
  output logic [CW-1:0] mask,
  output logic          il
);
  logic          busy_q, busy_d;
  logic [CW-1:0] k_q, k_d;
  logic [CW-1:0] base_q, base_d;
  logic [LW-1:0] lg_q, lg_d;
  logic          il_q, il_d;
  logic          en;
  logic [CW:0]   span;

  assign span = ({{CW{1'b0}}, 1'b1} << lg_q) - 1'b1;
  assign mask = span[CW-1:0];
  assign last = busy_q && (k_q == mask);

  always_comb begin
    busy_d = busy_q;
    k_d    = k_q;
    base_d = base_q;
    lg_d   = lg_q;
    il_d   = il_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        k_d    = '0;
        base_d = start_col;
        lg_d   = (err || (start_wr && wr_single)) ? '0 : lg_mode;
        il_d   = il_mode;
      end
    end else if (stop || last) begin
      busy_d = 1'b0;
    end else begin
      k_d = k_q + 1'b1;
    end
  end

  assign en = start | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      base_q <= '0;
      lg_q   <= '0;
      il_q   <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      k_q    <= k_d;
      base_q <= base_d;
      lg_q   <= lg_d;
      il_q   <= il_d;
    end
  end

  assign busy = busy_q;
  assign base = base_q;
  assign beat = k_q;
  assign il   = il_q;
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] beat,
  input  logic [CW-1:0] mask,
  input  logic          il,
  output logic [CW-1:0] addr
);
  logic [CW-1:0] seq_addr, il_addr, sum;

  assign sum      = base + beat;
  assign seq_addr = (base & ~mask) | (sum & mask);
  assign il_addr  = base ^ (beat & mask);
  assign addr     = il ? il_addr : seq_addr;
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ld,
  input  logic [MW-1:0] mode_din,
  input  logic          start,
  input  logic          start_wr,
  input  logic [CW-1:0] start_col,
  input  logic          stop,
  output logic [CW-1:0] col_addr,
  output logic          col_vld,
  output logic          col_last,
  output logic          mode_err
);
  localparam int LW = $clog2(CW + 1);

  logic [LW-1:0] lg_mode;
  logic          il_mode, wr_single, err;
  logic          busy, last, il;
  logic [CW-1:0] base, beat, mask;

  colgen_mode_dec #(.MW(MW), .LW(LW)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_din(mode_din),
    .lg_mode(lg_mode), .il_mode(il_mode), .wr_single(wr_single), .err(err)
  );

  colgen_seq #(.CW(CW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_col(start_col), .stop(stop), .lg_mode(lg_mode),
    .il_mode(il_mode), .wr_single(wr_single), .err(err),
    .busy(busy), .last(last), .base(base), .beat(beat), .mask(mask), .il(il)
  );

  colgen_addr #(.CW(CW)) u_addr (
    .base(base), .beat(beat), .mask(mask), .il(il), .addr(col_addr)
  );

  assign col_vld  = busy;
  assign col_last = last;
  assign mode_err = err;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          start_wr,
  input logic [CW-1:0] start_col,
  input logic          stop,
  input logic [CW-1:0] col_addr,
  input logic          col_vld,
  input logic          col_last,
  input logic          mode_err,
  input logic          wr_single
);
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !col_vld) |=> (col_vld && col_addr == $past(start_col))); // R3

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !col_last && !stop) |=> col_vld); // R4

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !col_vld && mode_err) |=> col_last); // R8

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !col_vld && start_wr && wr_single) |=> col_last); // R9

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && stop) |=> !col_vld); // R10

  AST_LAST_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_vld); // R11

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |=> !col_vld); // R11
endmodule

bind sdram_burst_colgen colgen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
  .start_col(start_col), .stop(stop), .col_addr(col_addr),
  .col_vld(col_vld), .col_last(col_last), .mode_err(mode_err),
  .wr_single(wr_single)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_ld;
  logic [9:0] mode_din;
  logic       start, start_wr, stop;
  logic [7:0] start_col;
  logic [7:0] col_addr;
  logic       col_vld, col_last, mode_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] q_addr[$];
  logic       q_last[$];
  string      q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen u0 (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_din(mode_din),
    .start(start), .start_wr(start_wr), .start_col(start_col), .stop(stop),
    .col_addr(col_addr), .col_vld(col_vld), .col_last(col_last),
    .mode_err(mode_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare every produced beat
  always @(negedge clk) begin
    if (rst_n === 1'b1 && col_vld === 1'b1) begin
      if (q_addr.size() == 0) begin
        chk("R3 unexpected beat", 32'(col_addr), 32'hFFFF_FFFF);
      end else begin
        logic [7:0] ea;
        logic el;
        string r;
        ea = q_addr.pop_front();
        el = q_last.pop_front();
        r  = q_req.pop_front();
        chk({r, " addr"}, 32'(col_addr), 32'(ea));
        chk({r, " last"}, 32'(col_last), 32'(el));
      end
    end
  end

  function automatic logic [7:0] beat_col(input int col, input int k, input int n, input bit ilv);
    int blk, off;
    blk = (col / n) * n;
    off = col % n;
    if (ilv) return 8'(blk + (off ^ k));
    return 8'(blk + ((off + k) % n));
  endfunction

  task automatic load_mode(input logic [9:0] m, input logic exp_err, input string req);
    @(negedge clk);
    mode_ld  = 1'b1;
    mode_din = m;
    @(negedge clk);
    mode_ld  = 1'b0;
    chk({req, " mode_err"}, 32'(mode_err), 32'(exp_err));
  endtask

  // n: expected length, stop_after: beats before stop (0 = no stop)
  task automatic burst(input logic [7:0] col, input logic wr, input int n,
                       input bit ilv, input int stop_after, input string req);
    int emit;
    emit = (stop_after > 0 && stop_after < n) ? stop_after : n;
    for (int k = 0; k < emit; k++) begin
      q_addr.push_back(beat_col(col, k, n, ilv));
      q_last.push_back(k == n - 1);
      q_req.push_back(req);
    end
    @(negedge clk);
    start = 1'b1; start_wr = wr; start_col = col;
    for (int i = 1; i <= emit + 2; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (stop_after > 0 && i == stop_after) stop = 1'b1;
      if (i == stop_after + 1) stop = 1'b0;
    end
    chk({req, " queue drained"}, 32'(q_addr.size()), 32'd0);
    chk({req, " idle after burst"}, 32'(col_vld), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_ld = 1'b0; mode_din = '0;
    start = 1'b0; start_wr = 1'b0; start_col = '0; stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 col_vld", 32'(col_vld), 0);
    chk("R1 col_last", 32'(col_last), 0);
    chk("R1 mode_err", 32'(mode_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cleared mode gives single-beat sequential
    burst(8'h42, 1'b0, 1, 1'b0, 0, "R1");

    // R2/R4/R5: length 4 sequential wrap
    load_mode(10'h002, 1'b0, "R2");
    burst(8'h0D, 1'b0, 4, 1'b0, 0, "R5");
    // R4: length 2 at top of range
    load_mode(10'h001, 1'b0, "R4");
    burst(8'hFF, 1'b1, 2, 1'b0, 0, "R4");
    // R6: interleaved length 8
    load_mode(10'h00B, 1'b0, "R6");
    burst(8'h35, 1'b0, 8, 1'b1, 0, "R6");
    // R6: interleaved length 4
    load_mode(10'h00A, 1'b0, "R6");
    burst(8'h92, 1'b0, 4, 1'b1, 0, "R6");

    // R7: full page with wrap
    load_mode(10'h007, 1'b0, "R7");
    burst(8'hF0, 1'b0, 256, 1'b0, 0, "R7");
    // R10: stop in full page
    burst(8'h10, 1'b0, 256, 1'b0, 5, "R10");
    // R10: stop at length 8
    load_mode(10'h003, 1'b0, "R10");
    burst(8'h21, 1'b1, 8, 1'b0, 3, "R10");

    // R10: stop while idle has no effect on a following burst
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R10 idle stop", 32'(col_vld), 0);
    burst(8'h05, 1'b0, 8, 1'b0, 0, "R10");

    // R3: start during a burst is ignored
    for (int k = 0; k < 8; k++) begin
      q_addr.push_back(beat_col(8'h60, k, 8, 1'b0));
      q_last.push_back(k == 7);
      q_req.push_back("R3");
    end
    @(negedge clk); start = 1'b1; start_col = 8'h60; start_wr = 1'b0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; start_col = 8'hC3;
    @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    chk("R3 queue drained", 32'(q_addr.size()), 0);
    chk("R3 idle", 32'(col_vld), 0);

    // R8: reserved codes
    load_mode(10'h004, 1'b1, "R8");
    burst(8'h33, 1'b0, 1, 1'b0, 0, "R8");
    load_mode(10'h006, 1'b1, "R8");
    burst(8'h34, 1'b1, 1, 1'b0, 0, "R8");
    load_mode(10'h00F, 1'b1, "R8");
    burst(8'h35, 1'b0, 1, 1'b0, 0, "R8");

    // R9: write single, read full length
    load_mode(10'h203, 1'b0, "R9");
    burst(8'h47, 1'b1, 1, 1'b0, 0, "R9");
    burst(8'h47, 1'b0, 8, 1'b0, 0, "R9");
    // R11: last on beat N-1 only after back to normal
    load_mode(10'h002, 1'b0, "R11");
    burst(8'hAB, 1'b0, 4, 1'b0, 0, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule